// File: doc/BRIEF.md
# Locked Test-and-Clear Byte Shift Sequencer

This block sequences byte-wide memory operations for a CPU that sits behind a small direct-mapped cache and a 16-bit memory bus. It accepts one request at a time: a plain byte load, a plain byte store, or a semaphore operation. The semaphore operation is an arithmetic shift right by one of a byte held in memory. Loads and stores use the cache unless the request's page-bypass attribute is set. The semaphore operation always reads and writes main memory directly and holds the bus lock for the whole read-modify-write.

For a byte that holds 0 or 1, the shift works as a test-and-clear: the old low bit comes back in the carry flag and the byte is left at zero. If the byte read is already zero, the unit issues no write cycle and releases the lock right after the read. When a bypassed store or a semaphore write-back hits a cached word, that cache line is invalidated so that later cached loads fetch fresh data. The internal cache is a tag-and-word model with lookup, fill, byte update and invalidate.

Top module: `sem_shift_unit`

## Requirements
- R1: A semaphore request (op code 2) always makes a bus read (mem_we_o=0, mem_be_o=2'b11), even when the addressed word is cached. It is never answered from the cache.
- R2: mem_lock_o is high during every bus cycle of a semaphore request, from the cycle after acceptance until the last acknowledge. It is low in the done cycle and during every non-semaphore request.
- R3: The semaphore result is {b[7], b[7:1]}, where b is the byte read. It is returned on rdata_o and written back, and C equals b[0].
- R4: At done_o, N = result[7] and Z = (result == 0). For a semaphore, V = N XOR C. For a load (op 0) the result is the byte loaded, for a store (op 1) it is the store data, and in both cases V = C = 0.
- R5: When a semaphore reads a zero byte, no write cycle is issued, C = 0 and Z = 1.
- R6: Byte address bit 0 selects the lane: 0 selects bits 7:0 and mem_be_o=2'b01, and 1 selects bits 15:8 and mem_be_o=2'b10. A write asserts exactly the selected lane's strobe. mem_addr_o is the byte address shifted right by one.
- R7: A non-bypassed load that hits the cache completes with no bus cycle. A non-bypassed load that misses does one full-word read and fills the line.
- R8: With req_bypass_i=1, a load always reads the bus and never fills the cache. A store always writes the bus.
- R9: A bypassed store or a semaphore write that hits a cached word invalidates that line. A non-bypassed store that hits updates the cached byte. Later loads return the current memory value.
- R10: Requests are accepted only while req_ready_o=1, which is the idle state. A request presented while busy has no effect. req_ready_o returns the cycle after done_o.
- R11: After reset, req_ready_o=1 and done_o, mem_req_o and mem_lock_o are 0, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken when req_ready_o is high |
| req_op_i | input | 2 | 0 load, 1 store, 2 semaphore shift (3 acts as load) |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | 8 | Store data |
| req_bypass_i | input | 1 | Page cache-bypass attribute |
| req_ready_o | output | 1 | Unit idle |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 8 | Loaded byte, store data or shift result |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |
| mem_req_o | output | 1 | Bus cycle request, held until acknowledge |
| mem_we_o | output | 1 | Bus write |
| mem_addr_o | output | AW-1 | Word address |
| mem_be_o | output | 2 | Byte-lane strobes |
| mem_wdata_o | output | 16 | Write data (byte on both lanes) |
| mem_lock_o | output | 1 | Bus lock |
| mem_ack_i | input | 1 | Bus acknowledge |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |

## Verification
A corrupted lock or phase state shows up at the bus within one cycle. It appears as an unlocked semaphore cycle, a write issued after a zero read, or a lock held into the done cycle. A stale or wrongly filled cache line stays hidden until the next load of that word. That load either makes no bus cycle when it should, or returns a byte that differs from memory, so each coherence case is followed by a reload of the same word. Lane errors show up on the very write that uses the wrong strobe, and in the memory word checked when the operation completes.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_SEM   = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_RD,
    ST_WR,
    ST_FIN
  } state_e;
endpackage

// File: rtl/sem_shift_alu.sv
module sem_shift_alu
  import sem_pkg::*;
(
  input  logic [1:0] op_i,
  input  logic [7:0] byte_i,
  output logic [7:0] res_o,
  output logic       n_o,
  output logic       z_o,
  output logic       v_o,
  output logic       c_o
);
  logic is_sem;
  assign is_sem = (op_i == OP_SEM);

  always_comb begin
    if (is_sem) begin
      res_o = {byte_i[7], byte_i[7:1]};
      c_o   = byte_i[0];
    end else begin
      res_o = byte_i;
      c_o   = 1'b0;
    end
    n_o = res_o[7];
    z_o = (res_o == 8'h00);
    v_o = is_sem ? (n_o ^ c_o) : 1'b0;
  end
endmodule

// File: rtl/sem_tag_cache.sv
module sem_tag_cache #(
  parameter int AW    = 8,
  parameter int LINES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-2:0] waddr_i,
  output logic          hit_o,
  output logic [15:0]   data_o,
  input  logic          fill_i,
  input  logic [15:0]   fill_data_i,
  input  logic          upd_i,
  input  logic          upd_lane_i,
  input  logic [7:0]    upd_byte_i,
  input  logic          inv_i
);
  localparam int WAW  = AW - 1;
  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = WAW - IDXW;

  logic [LINES-1:0] valid_q;
  logic [TAGW-1:0]  tag_q  [LINES];
  logic [15:0]      data_q [LINES];
  logic [IDXW-1:0]  idx;
  logic [TAGW-1:0]  tag;
  logic [LINES-1:0] match;

  assign idx = waddr_i[IDXW-1:0];
  assign tag = waddr_i[WAW-1:IDXW];

  for (genvar i = 0; i < LINES; i++) begin : g_match
    assign match[i] = valid_q[i] && (tag_q[i] == tag) && (idx == IDXW'(i));
  end

  assign hit_o  = |match;
  assign data_o = data_q[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (fill_i) begin
      valid_q[idx] <= 1'b1;
      tag_q[idx]   <= tag;
      data_q[idx]  <= fill_data_i;
    end else if (inv_i) begin
      valid_q[idx] <= 1'b0;
    end else if (upd_i) begin
      if (upd_lane_i) data_q[idx][15:8] <= upd_byte_i;
      else            data_q[idx][7:0]  <= upd_byte_i;
    end
  end

  assert_fill_excl_inv_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> !inv_i && !upd_i);
  assert_inv_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && !fill_i) |=> !hit_o || ($past(waddr_i) != waddr_i));
endmodule

// File: rtl/sem_seq.sv
module sem_seq
  import sem_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [7:0]    req_wdata_i,
  input  logic          req_bypass_i,
  output logic          ready_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-2:0] mem_addr_o,
  output logic [1:0]    mem_be_o,
  output logic [15:0]   mem_wdata_o,
  output logic          mem_lock_o,
  input  logic          mem_ack_i,
  input  logic [15:0]   mem_rdata_i,
  output logic [AW-2:0] c_waddr_o,
  input  logic          c_hit_i,
  input  logic [15:0]   c_data_i,
  output logic          c_fill_o,
  output logic [15:0]   c_fill_data_o,
  output logic          c_upd_o,
  output logic          c_lane_o,
  output logic [7:0]    c_byte_o,
  output logic          c_inv_o,
  output logic [1:0]    alu_op_o,
  output logic [7:0]    alu_in_o,
  input  logic [7:0]    alu_res_i
);
  state_e        st_q, st_d;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic          byp_q;
  logic [7:0]    byte_q;
  logic          lane;
  logic [7:0]    bus_byte;
  logic [7:0]    line_byte;
  logic          is_sem, is_st, is_ld, ld_hit;

  assign lane      = addr_q[0];
  assign bus_byte  = lane ? mem_rdata_i[15:8] : mem_rdata_i[7:0];
  assign line_byte = lane ? c_data_i[15:8]    : c_data_i[7:0];
  assign is_sem    = (op_q == OP_SEM);
  assign is_st     = (op_q == OP_STORE);
  assign is_ld     = !is_sem && !is_st;
  assign ld_hit    = is_ld && !byp_q && c_hit_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_CHK;
      ST_CHK: begin
        if (is_st)       st_d = ST_WR;
        else if (ld_hit) st_d = ST_FIN;
        else             st_d = ST_RD;
      end
      ST_RD:   if (mem_ack_i) st_d = (is_sem && bus_byte != 8'h00) ? ST_WR : ST_FIN;
      ST_WR:   if (mem_ack_i) st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= 2'd0;
      addr_q <= '0;
      byp_q  <= 1'b0;
      byte_q <= 8'h00;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_valid_i) begin
        op_q   <= req_op_i;
        addr_q <= req_addr_i;
        byp_q  <= req_bypass_i;
        byte_q <= req_wdata_i;
      end else if (st_q == ST_CHK && ld_hit) begin
        byte_q <= line_byte;
      end else if (st_q == ST_RD && mem_ack_i) begin
        byte_q <= bus_byte;
      end
    end
  end

  assign ready_o     = (st_q == ST_IDLE);
  assign done_o      = (st_q == ST_FIN);
  assign mem_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_addr_o  = addr_q[AW-1:1];
  assign mem_be_o    = mem_we_o ? (lane ? 2'b10 : 2'b01) : 2'b11;
  assign mem_wdata_o = {alu_res_i, alu_res_i};
  // lock spans the setup cycle so it is up before the read request
  assign mem_lock_o  = is_sem && ((st_q == ST_CHK) || (st_q == ST_RD) || (st_q == ST_WR));

  assign c_waddr_o     = addr_q[AW-1:1];
  assign c_fill_o      = (st_q == ST_RD) && mem_ack_i && is_ld && !byp_q;
  assign c_fill_data_o = mem_rdata_i;
  assign c_upd_o       = (st_q == ST_WR) && mem_ack_i && is_st && !byp_q && c_hit_i;
  assign c_inv_o       = (st_q == ST_WR) && mem_ack_i && (byp_q || is_sem) && c_hit_i;
  assign c_lane_o      = lane;
  assign c_byte_o      = byte_q;

  assign alu_op_o = op_q;
  assign alu_in_o = byte_q;

  assert_lock_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_lock_o && !mem_ack_i) |=> mem_lock_o);
  assert_lock_off_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_lock_o);
  assert_no_zero_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && is_sem) |-> (byte_q != 8'h00));
  assert_one_lane_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> ($countones(mem_be_o) == 1));
  assert_hit_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CHK && ld_hit) |=> !mem_req_o && done_o);
  assert_sem_reads_bus_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CHK && is_sem) |=> mem_req_o && !mem_we_o);
  assert_idle_after_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o);
endmodule

// File: rtl/sem_shift_unit.sv
module sem_shift_unit #(
  parameter int AW    = 8,
  parameter int LINES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [7:0]    req_wdata_i,
  input  logic          req_bypass_i,
  output logic          req_ready_o,
  output logic          done_o,
  output logic [7:0]    rdata_o,
  output logic          flag_n_o,
  output logic          flag_z_o,
  output logic          flag_v_o,
  output logic          flag_c_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-2:0] mem_addr_o,
  output logic [1:0]    mem_be_o,
  output logic [15:0]   mem_wdata_o,
  output logic          mem_lock_o,
  input  logic          mem_ack_i,
  input  logic [15:0]   mem_rdata_i
);
  logic [AW-2:0] c_waddr;
  logic          c_hit, c_fill, c_upd, c_lane, c_inv;
  logic [15:0]   c_data, c_fill_data;
  logic [7:0]    c_byte;
  logic [1:0]    alu_op;
  logic [7:0]    alu_in, alu_res;

  sem_seq #(.AW(AW)) u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_op_i, .req_addr_i, .req_wdata_i, .req_bypass_i,
    .ready_o(req_ready_o), .done_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o, .mem_lock_o,
    .mem_ack_i, .mem_rdata_i,
    .c_waddr_o(c_waddr), .c_hit_i(c_hit), .c_data_i(c_data), .c_fill_o(c_fill),
    .c_fill_data_o(c_fill_data), .c_upd_o(c_upd), .c_lane_o(c_lane), .c_byte_o(c_byte),
    .c_inv_o(c_inv), .alu_op_o(alu_op), .alu_in_o(alu_in), .alu_res_i(alu_res)
  );

  sem_tag_cache #(.AW(AW), .LINES(LINES)) u_cache (
    .clk_i, .rst_ni, .waddr_i(c_waddr), .hit_o(c_hit), .data_o(c_data),
    .fill_i(c_fill), .fill_data_i(c_fill_data), .upd_i(c_upd), .upd_lane_i(c_lane),
    .upd_byte_i(c_byte), .inv_i(c_inv)
  );

  sem_shift_alu u_alu (
    .op_i(alu_op), .byte_i(alu_in), .res_o(alu_res),
    .n_o(flag_n_o), .z_o(flag_z_o), .v_o(flag_v_o), .c_o(flag_c_o)
  );

  assign rdata_o = alu_res;

  assert_done_flags_v_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && alu_op != 2'd2) |-> !flag_v_o && !flag_c_o);
endmodule

// File: tb/tb_sem_shift_unit.sv
module tb_sem_shift_unit;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [7:0]  req_addr = 8'h00;
  logic [7:0]  req_wdata = 8'h00;
  logic        req_bypass = 1'b0;
  logic        ready, done, fn, fz, fv, fc;
  logic [7:0]  rdata;
  logic        mreq, mwe, mlock;
  logic [6:0]  maddr;
  logic [1:0]  mbe;
  logic [15:0] mwdata;
  logic        mack;
  logic [15:0] mrdata;

  always #5 clk = ~clk;

  sem_shift_unit #(.AW(AW), .LINES(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_bypass_i(req_bypass),
    .req_ready_o(ready), .done_o(done), .rdata_o(rdata),
    .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_be_o(mbe),
    .mem_wdata_o(mwdata), .mem_lock_o(mlock), .mem_ack_i(mack), .mem_rdata_i(mrdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder
  logic [15:0] mem     [128];
  logic [15:0] exp_mem [128];
  int lat = 0;
  int cnt = 0;
  initial for (int i = 0; i < 128; i++) begin mem[i] = 16'h0; exp_mem[i] = 16'h0; end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mack <= 1'b0; mrdata <= 16'h0; cnt <= 0;
    end else if (mack) begin
      mack <= 1'b0;
    end else if (mreq && cnt >= lat) begin
      mack <= 1'b1; cnt <= 0;
      mrdata <= mem[maddr];
      if (mwe) begin
        if (mbe[0]) mem[maddr][7:0]  <= mwdata[7:0];
        if (mbe[1]) mem[maddr][15:8] <= mwdata[15:8];
      end
    end else if (mreq) begin
      cnt <= cnt + 1;
    end
  end

  // reference: expected bus cycles {lock, we, be, waddr, byte}
  logic [18:0] txq [$];
  bit cur_sem = 0;
  bit        cm_v [4];
  logic [4:0] cm_t [4];
  logic [15:0] cm_d [4];
  initial for (int i = 0; i < 4; i++) begin cm_v[i] = 0; cm_t[i] = 0; cm_d[i] = 0; end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cur_sem && mlock) chk(0, "R2 lock outside semaphore", 1, 0);
      if (cur_sem && mreq) chk(mlock, "R2 lock on semaphore bus cycle", mlock, 1);
      if (mreq && mack) begin
        if (txq.size() == 0) chk(0, "R1/R5/R7/R8 unexpected bus cycle", {mwe, maddr}, 0);
        else begin
          logic [18:0] e;
          logic [7:0]  wb;
          e = txq.pop_front();
          wb = mbe[1] ? mwdata[15:8] : mwdata[7:0];
          chk(mwe == e[17] && mbe == e[16:15] && maddr == e[14:8],
              "R1/R6/R8 bus cycle kind/lane/addr", {mwe, mbe, maddr}, e[17:8]);
          if (e[17]) chk(wb == e[7:0], "R3 written byte", wb, e[7:0]);
        end
      end
    end
  end

  task automatic do_op(input int op, input int addr, input int wd, input bit byp,
                       input bit poke, input string tag);
    int waddr, idx, tg, to;
    bit lane, hit;
    logic [7:0] b, res;
    bit en, ez, ev, ec;
    waddr = addr >> 1; lane = addr[0]; idx = waddr % 4; tg = waddr >> 2;
    hit = cm_v[idx] && cm_t[idx] == 5'(tg);
    b = lane ? exp_mem[waddr][15:8] : exp_mem[waddr][7:0];
    ec = 0; ev = 0;
    case (op)
      0: begin
        if (hit && !byp) b = lane ? cm_d[idx][15:8] : cm_d[idx][7:0];
        else begin
          txq.push_back({1'b0, 1'b0, 2'b11, 7'(waddr), 8'h0});
          if (!byp) begin cm_v[idx] = 1; cm_t[idx] = 5'(tg); cm_d[idx] = exp_mem[waddr]; end
        end
        res = b;
      end
      1: begin
        res = 8'(wd);
        txq.push_back({1'b0, 1'b1, lane ? 2'b10 : 2'b01, 7'(waddr), res});
        if (lane) exp_mem[waddr][15:8] = res; else exp_mem[waddr][7:0] = res;
        if (hit) begin
          if (byp) cm_v[idx] = 0;
          else if (lane) cm_d[idx][15:8] = res; else cm_d[idx][7:0] = res;
        end
      end
      default: begin
        res = {b[7], b[7:1]}; ec = b[0];
        txq.push_back({1'b1, 1'b0, 2'b11, 7'(waddr), 8'h0});
        if (b != 0) begin
          txq.push_back({1'b1, 1'b1, lane ? 2'b10 : 2'b01, 7'(waddr), res});
          if (lane) exp_mem[waddr][15:8] = res; else exp_mem[waddr][7:0] = res;
          if (hit) cm_v[idx] = 0;
        end
      end
    endcase
    en = res[7]; ez = (res == 0);
    if (op == 2) ev = en ^ ec;

    while (!ready) @(negedge clk);
    cur_sem = (op == 2);
    req_valid = 1; req_op = 2'(op); req_addr = 8'(addr); req_wdata = 8'(wd); req_bypass = byp;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin  // R10: stray request while busy
      req_valid = 1; req_op = 2'd1; req_addr = 8'h40; req_wdata = 8'hEE; req_bypass = 1;
      chk(!ready, "R10 ready low while busy", ready, 0);
      @(negedge clk); @(negedge clk);
      req_valid = 0;
    end
    to = 0;
    while (!done && to < 50) begin @(negedge clk); to++; end
    chk(done, {tag, " done"}, done, 1);
    chk(rdata == res, {tag, " R3/R4 rdata"}, rdata, res);
    chk({fn, fz, fv, fc} == {en, ez, ev, ec}, {tag, " R4 flags NZVC"},
        {fn, fz, fv, fc}, {en, ez, ev, ec});
    chk(!mlock, {tag, " R2 lock low at done"}, mlock, 0);
    chk(txq.size() == 0, {tag, " R1/R5/R7 missing bus cycles"}, txq.size(), 0);
    chk(mem[waddr] == exp_mem[waddr], {tag, " R6 memory word"}, mem[waddr], exp_mem[waddr]);
    @(negedge clk);
    cur_sem = 0;
    chk(ready, {tag, " R10 ready after done"}, ready, 1);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(ready && !done && !mreq && !mlock, "R11 reset outputs", {ready, done, mreq, mlock}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    // R6 lanes, R4 store flags
    do_op(1, 8'h10, 8'h01, 0, 0, "st even");
    do_op(1, 8'h11, 8'h80, 0, 0, "st odd");
    do_op(1, 8'h23, 8'h55, 0, 0, "st odd2");
    lat = 2;
    // R7 miss fills, then hits on both bytes
    do_op(0, 8'h10, 0, 0, 0, "R7 ld miss");
    do_op(0, 8'h10, 0, 0, 0, "R7 ld hit");
    do_op(0, 8'h11, 0, 0, 0, "R7 ld hit odd");
    // R1 semaphore on cached word, value 1 -> 0, C=1; R9 invalidates
    do_op(2, 8'h10, 0, 0, 0, "R1 sem one");
    do_op(0, 8'h10, 0, 0, 0, "R9 reload after sem");
    // R5 zero byte: no write
    lat = 0;
    do_op(2, 8'h10, 0, 0, 0, "R5 sem zero");
    // R3 arithmetic shift keeps bit 7
    do_op(2, 8'h11, 0, 0, 0, "R3 sem 80");
    do_op(2, 8'h23, 0, 1, 0, "R3 sem 55");
    // R9 bypassed store on cached word invalidates
    do_op(0, 8'h20, 0, 0, 0, "R9 fill");
    do_op(1, 8'h21, 8'hA5, 1, 0, "R8 byp st");
    do_op(0, 8'h21, 0, 0, 0, "R9 reload after byp st");
    // R8 bypassed load: bus, no fill
    do_op(0, 8'h50, 0, 1, 0, "R8 byp ld");
    do_op(0, 8'h50, 0, 0, 0, "R8 miss after byp ld");
    // R9 non-bypassed store hit updates cache
    do_op(0, 8'h30, 0, 0, 0, "R9 fill2");
    do_op(1, 8'h30, 8'h77, 0, 0, "R9 st hit");
    do_op(0, 8'h30, 0, 0, 0, "R9 hit updated");
    // R10 stray request while busy
    lat = 3;
    do_op(2, 8'h11, 0, 0, 1, "R10 busy sem");
    chk(mem[8'h20] == exp_mem[8'h20], "R10 stray store ignored", mem[8'h20], exp_mem[8'h20]);
    lat = 1;
    do_op(1, 8'h61, 8'h01, 1, 0, "st lock word");
    do_op(2, 8'h61, 0, 0, 0, "R1 sem odd one");
    do_op(2, 8'h61, 0, 0, 0, "R5 sem odd zero");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule